// File: doc/BRIEF.md
# Field-Configurable Two-Level Logic Array with Bidirectional Pins

This block is a configurable sum-of-products array. Twelve dedicated inputs and ten bidirectional pins form 22 sources. Each source supplies a true and an inverted literal to a bank of 42 product terms. Thirty-two of those terms are logic terms, and any of them can be routed into any of ten OR gates. Each OR result passes through a per-pin polarity stage before it reaches the pin driver. The remaining ten terms are direction terms: each one enables the driver of one pin. The value seen on every pin is fed back into the array, whether or not the pin is being driven, so a pin can serve as an input, an output, or a feedback node.

The connection pattern is held in a single shift chain. It is loaded one bit per clock, first bit first, while the load strobe is high. While the strobe is high, every pin driver is released. Each pin is carried as three separate signals (value in, value out, drive enable), so the surrounding logic or the bench resolves the pin level without real tri-state nets.

Chain layout, from the least significant bit up:
- Bits 0 to 9 are the polarity bits.
- The next 320 bits are OR links, indexed (term × 10 + output).
- The top 1848 bits are AND links, indexed (term × 44 + literal).

For literals, literal 2s is source s true and literal 2s+1 is source s inverted. Sources 0 to 11 are the inputs, and source 12+n is pin n. Terms 0 to 31 are logic terms, and term 32+n is the direction term of pin n. A link bit of 0 means connected and 1 means removed.

Top module: `cfg_pla`

## Requirements
- R1: After reset the chain holds all zeros, so every term holds both literals of each source and evaluates 0; b_oe is all zero and b_out is all ones.
- R2: While cfg_en is high, b_oe is all zero.
- R3: Each cycle with cfg_en high shifts cfg_data into chain bit 0 and moves every bit up one place; after 2178 such cycles the first bit sent sits in bit 2177, using the layout given above.
- R4: A product term is the AND of its connected literals; a term with every literal removed evaluates 1.
- R5: A term that keeps both the true and the inverted literal of one source evaluates 0.
- R6: Each OR sum is the OR of the logic terms connected to it; a removed link contributes 0.
- R7: Polarity bit 1 puts the OR sum on b_out, and polarity bit 0 puts its complement.
- R8: With cfg_en low, b_oe[n] equals direction term 32+n.
- R9: b_in[n] feeds source 12+n in all cases, including when pin n is driven, so a driven pin's value reaches other terms.
- R10: With cfg_en low, cfg_data has no effect and the configuration is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset; clears the chain |
| cfg_en | input | 1 | Shift strobe; also releases all drivers |
| cfg_data | input | 1 | Serial configuration bit |
| in_pins | input | 12 | Dedicated inputs |
| b_in | input | 10 | Resolved level present on each bidirectional pin |
| b_out | output | 10 | Value each pin driver would drive |
| b_oe | output | 10 | Driver enable per pin |

## Verification
The bench builds the block with its default sizes: 12 inputs, 10 pins and 32 logic terms, which gives a 2178-bit chain. With these sizes every direction term, every polarity bit and the full OR routing can be reached with a full-length load. A directed pattern covers the empty term, the contradictory term, inverted polarity, and a driven pin feeding another driven pin. Random patterns keep feedback limited to undriven pins, so the pin levels that the bench resolves always settle.

// File: rtl/cfg_pla_pkg.sv
package cfg_pla_pkg;
  localparam int unsigned PLA_N_IN  = 12;
  localparam int unsigned PLA_N_BIO = 10;
  localparam int unsigned PLA_N_LT  = 32;

  // total chain length for a given array shape
  function automatic int unsigned chain_len(input int unsigned n_in,
                                            input int unsigned n_bio,
                                            input int unsigned n_lt);
    int unsigned lits;
    lits = 2 * (n_in + n_bio);
    return (n_lt + n_bio) * lits + n_lt * n_bio + n_bio;
  endfunction
endpackage

// File: rtl/cfg_pla_chain.sv
module cfg_pla_chain #(
  parameter int unsigned LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_bit,
  output logic [LEN-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits <= '0;
    else if (shift_en) bits <= {bits[LEN-2:0], shift_bit};
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(bits));

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (bits[0] == $past(shift_bit)));
endmodule

// File: rtl/cfg_pla_and_plane.sv
module cfg_pla_and_plane #(
  parameter int unsigned N_SRC = 22,
  parameter int unsigned N_PT  = 42,
  localparam int unsigned N_LIT = 2 * N_SRC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      src,
  input  logic [N_PT*N_LIT-1:0] cut,
  output logic [N_PT-1:0]       terms
);
  logic [N_LIT-1:0] lits;

  // literal 2s = true, 2s+1 = inverted
  for (genvar s = 0; s < N_SRC; s++) begin : g_lit
    assign lits[2*s]   = src[s];
    assign lits[2*s+1] = ~src[s];
  end

  function automatic logic term_value(input logic [N_LIT-1:0] l,
                                      input logic [N_LIT-1:0] c);
    return &(l | c);
  endfunction

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_LIT-1:0] row;
    assign row      = cut[p*N_LIT +: N_LIT];
    assign terms[p] = term_value(lits, row);

    assert_empty_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (&row) |-> terms[p]);

    assert_contra_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!row[0] && !row[1]) |-> !terms[p]);
  end
endmodule

// File: rtl/cfg_pla_or_plane.sv
module cfg_pla_or_plane #(
  parameter int unsigned N_LT  = 32,
  parameter int unsigned N_OUT = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_LT-1:0]        terms,
  input  logic [N_LT*N_OUT-1:0]  cut,
  input  logic [N_OUT-1:0]       pol,
  output logic [N_OUT-1:0]       sum,
  output logic [N_OUT-1:0]       out
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_LT-1:0] conn;
    for (genvar t = 0; t < N_LT; t++) begin : g_link
      assign conn[t] = ~cut[t*N_OUT + o];
    end
    assign sum[o] = |(terms & conn);
    assign out[o] = sum[o] ^ ~pol[o];
  end

  assert_idle_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (terms == '0) |-> (out == ~pol));
endmodule

// File: rtl/cfg_pla.sv
module cfg_pla
  import cfg_pla_pkg::*;
#(
  parameter int unsigned N_IN  = PLA_N_IN,
  parameter int unsigned N_BIO = PLA_N_BIO,
  parameter int unsigned N_LT  = PLA_N_LT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_data,
  input  logic [N_IN-1:0]  in_pins,
  input  logic [N_BIO-1:0] b_in,
  output logic [N_BIO-1:0] b_out,
  output logic [N_BIO-1:0] b_oe
);
  localparam int unsigned N_SRC    = N_IN + N_BIO;
  localparam int unsigned N_LIT    = 2 * N_SRC;
  localparam int unsigned N_PT     = N_LT + N_BIO;
  localparam int unsigned POL_BITS = N_BIO;
  localparam int unsigned OR_BITS  = N_LT * N_BIO;
  localparam int unsigned AND_BITS = N_PT * N_LIT;
  localparam int unsigned AND_BASE = POL_BITS + OR_BITS;
  localparam int unsigned CFG_LEN  = chain_len(N_IN, N_BIO, N_LT);

  logic [CFG_LEN-1:0] chain;
  logic [N_SRC-1:0]   src;
  logic [N_PT-1:0]    terms;
  logic [N_BIO-1:0]   ctrl_terms;
  logic [N_BIO-1:0]   or_sum;

  cfg_pla_chain #(.LEN(CFG_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .shift_bit(cfg_data),
    .bits     (chain)
  );

  // pins occupy sources N_IN .. N_SRC-1
  assign src = {b_in, in_pins};

  cfg_pla_and_plane #(.N_SRC(N_SRC), .N_PT(N_PT)) u_and (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (src),
    .cut  (chain[AND_BASE +: AND_BITS]),
    .terms(terms)
  );

  cfg_pla_or_plane #(.N_LT(N_LT), .N_OUT(N_BIO)) u_or (
    .clk  (clk),
    .rst_n(rst_n),
    .terms(terms[N_LT-1:0]),
    .cut  (chain[POL_BITS +: OR_BITS]),
    .pol  (chain[POL_BITS-1:0]),
    .sum  (or_sum),
    .out  (b_out)
  );

  assign ctrl_terms = terms[N_PT-1:N_LT];
  assign b_oe       = ctrl_terms & {N_BIO{~cfg_en}};

  assert_release_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (b_oe == '0));

  assert_driven_matches_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_oe != '0) && (or_sum == '0)) |-> ((b_out & b_oe) == (~chain[POL_BITS-1:0] & b_oe)));
endmodule

// File: tb/cfg_pla_bench.sv
module cfg_pla_bench;
  localparam int NI = 12, NB = 10, NL = 32;
  localparam int NS = NI + NB, NLIT = 2 * NS, NP = NL + NB;
  localparam int POLB = NB, ORB = NL * NB, ANDBASE = POLB + ORB;
  localparam int CB = ANDBASE + NP * NLIT;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_data = 0;
  logic [NI-1:0] in_pins = '0;
  logic [NB-1:0] b_in = '0;
  logic [NB-1:0] b_out, b_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  bit and_cut [NP][NLIT];
  bit or_cut  [NL][NB];
  bit pol     [NB];

  always #10 clk = ~clk;

  cfg_pla u_cfg_pla (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
                     .in_pins(in_pins), .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic bit cfg_bit(input int idx);
    int k;
    if (idx < POLB) return pol[idx];
    if (idx < ANDBASE) begin k = idx - POLB; return or_cut[k / NB][k % NB]; end
    k = idx - ANDBASE;
    return and_cut[k / NLIT][k % NLIT];
  endfunction

  task automatic model(input bit [NI-1:0] ins, input bit [NB-1:0] pins,
                       output bit [NB-1:0] oe, output bit [NB-1:0] out);
    bit sv [NS];
    bit t  [NP];
    for (int s = 0; s < NS; s++) sv[s] = (s < NI) ? ins[s] : pins[s - NI];
    for (int p = 0; p < NP; p++) begin
      t[p] = 1;
      for (int s = 0; s < NS; s++) begin
        if (!and_cut[p][2*s]   && !sv[s]) t[p] = 0;
        if (!and_cut[p][2*s+1] &&  sv[s]) t[p] = 0;
      end
    end
    for (int o = 0; o < NB; o++) begin
      bit acc = 0;
      for (int q = 0; q < NL; q++) if (!or_cut[q][o] && t[q]) acc = 1;
      out[o] = pol[o] ? acc : !acc;
      oe[o]  = t[NL + o];
    end
  endtask

  task automatic clear_cfg();
    for (int p = 0; p < NP; p++) for (int l = 0; l < NLIT; l++) and_cut[p][l] = 0;
    for (int q = 0; q < NL; q++) for (int o = 0; o < NB; o++) or_cut[q][o] = 1;
    for (int o = 0; o < NB; o++) pol[o] = 1;
  endtask

  task automatic only_lits(input int p, input int l1, input int l2);
    for (int l = 0; l < NLIT; l++) and_cut[p][l] = 1;
    if (l1 >= 0) and_cut[p][l1] = 0;
    if (l2 >= 0) and_cut[p][l2] = 0;
  endtask

  task automatic load_cfg();
    for (int i = CB - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1; cfg_data = cfg_bit(i);
      if (i == CB / 2) begin #2; check("R2 b_oe released while loading", b_oe, '0); end
    end
    @(negedge clk);
    cfg_en = 0; cfg_data = 0;
  endtask

  task automatic apply(input string req, input bit [NI-1:0] ins, input bit [NB-1:0] ext);
    bit [NB-1:0] pv, oe, out;
    pv = ext;
    for (int k = 0; k < 6; k++) begin
      model(ins, pv, oe, out);
      pv = (oe & out) | (~oe & ext);
    end
    model(ins, pv, oe, out);
    @(negedge clk);
    in_pins = ins; b_in = pv;
    #3;
    check({req, " R8 drive enables"}, b_oe, oe);
    check({req, " R6 R7 outputs"}, b_out, out);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [NI-1:0] ins;
    bit [NB-1:0] ext;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset b_oe", b_oe, '0);
    check("R1 reset b_out", b_out, '1);

    // directed pattern
    clear_cfg();
    only_lits(0, 0, 3);                 // term0 = I0 & ~I1
    or_cut[0][0] = 0; pol[0] = 1;
    only_lits(NL + 0, -1, -1);          // pin0 always driven (R4 empty term)
    or_cut[0][1] = 0; pol[1] = 0;       // pin1 = ~term0
    only_lits(NL + 1, 4, -1);           // pin1 driven when I2
    only_lits(1, 2 * (NI + 3), -1);     // term1 = B3
    or_cut[1][2] = 0;
    only_lits(NL + 2, -1, -1);          // pin2 driven
    // pin3 direction term keeps all literals: contradictory (R5)
    only_lits(2, 10, -1);               // term2 = I5
    or_cut[2][4] = 0;
    only_lits(NL + 4, -1, -1);
    only_lits(3, 2 * (NI + 4), -1);     // term3 = B4 (driven pin feedback)
    or_cut[3][6] = 0;
    only_lits(NL + 6, -1, -1);
    load_cfg();

    apply("R3 R4 dir", 12'h001, 10'h000);
    check("R4 empty term enables pin0", {9'd0, b_oe[0]}, 10'd1);
    check("R5 contradictory term keeps pin3 off", {9'd0, b_oe[3]}, 10'd0);
    apply("R7 dir", 12'h002, 10'h000);
    check("R7 inverted polarity pin1", {9'd0, b_out[1]}, 10'd1);
    apply("R9 dir", 12'h020, 10'h008);
    check("R9 undriven pin3 feeds pin2", {9'd0, b_out[2]}, 10'd1);
    check("R9 driven pin4 feeds pin6", {9'd0, b_out[6]}, 10'd1);
    apply("R9 dir", 12'h004, 10'h000);
    check("R9 driven pin4 low feeds pin6", {9'd0, b_out[6]}, 10'd0);

    // R10: data toggles with cfg_en low
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); cfg_data = 1'($urandom);
    end
    apply("R10 hold", 12'h001, 10'h000);
    apply("R10 hold", 12'h024, 10'h3f8);

    // random patterns, feedback only from undriven pins 5..9
    for (int c = 0; c < 5; c++) begin
      for (int p = 0; p < NP; p++) for (int l = 0; l < NLIT; l++) and_cut[p][l] = 1;
      for (int p = 0; p < NL; p++) begin
        int n = 1 + ($urandom % 3);
        for (int j = 0; j < n; j++) begin
          int s = $urandom % 17;
          if (s >= NI) s = s + 5;
          and_cut[p][2 * s + ($urandom % 2)] = 0;
        end
      end
      for (int o = 0; o < 5; o++) begin
        int n = $urandom % 3;
        for (int j = 0; j < n; j++) and_cut[NL + o][2 * ($urandom % NI) + ($urandom % 2)] = 0;
      end
      for (int o = 5; o < NB; o++) begin and_cut[NL + o][0] = 0; and_cut[NL + o][1] = 0; end
      for (int q = 0; q < NL; q++) for (int o = 0; o < NB; o++) or_cut[q][o] = ($urandom % 3) != 0;
      for (int o = 0; o < NB; o++) pol[o] = 1'($urandom);
      load_cfg();
      for (int v = 0; v < 30; v++) begin
        ins = NI'($urandom); ext = NB'($urandom);
        apply("R4 R5 R9 random", ins, ext);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule